// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept or dropped, based on its 48-bit destination address. The first header bytes of every frame arrive as a byte stream. The first byte of a frame is flagged with a start marker. The block captures the destination address, the type field and the control opcode. It runs a CRC-32 over the six address bytes. It then issues one registered decision per frame.

Several sub-filters each produce a verdict, and the verdicts are ORed together:

- a broadcast check;
- a bank of eight stored addresses, two of which carry a per-bit compare mask;
- a 512-bit hash bitmap indexed by nine CRC bits;
- an accept-every-multicast switch;
- promiscuous and accept-everything switches.

The stored-address result and the hash result can each be inverted. Flow-control pause frames are either handed to the MAC for consumption or, when forwarding is enabled, passed up like data.

Address, mask and bitmap storage are loaded through three simple write ports. The mode switches are static level inputs that must be held steady while a frame is being received.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, dec_valid, accept, exact_hit, hash_hit and pause_consume are 0. All stored addresses are zero, both masks are all ones, and the bitmap is all zeros.
- R2: Bytes are numbered from 0, where byte 0 is the byte with in_sof set. A new in_sof restarts numbering even in mid-frame. Destination bytes are 0..5, the type field is bytes 12..13 (high byte first), and the opcode is bytes 14..15. dec_valid pulses for one cycle, exactly once per frame. The pulse comes in the cycle after byte 13 is taken. When the destination is 01-80-C2-00-00-01 and the type is 0x8808, the pulse comes in the cycle after byte 15 instead.
- R3: A broadcast destination (all ones) is accepted by the broadcast sub-filter only when bcast_en is 1.
- R4: An address is held with byte 0 in bits 47:40. The exact sub-filter fires when exact_en is 1 and the destination equals any of the eight stored addresses; all eight are always compared.
- R5: Entries 0 and 1 each have a mask; a 0 mask bit drops that address bit from the compare. Mask writes to an index of 2 or more are ignored.
- R6: When exact_inv is 1, the exact sub-filter fires only when no stored entry matches.
- R7: The hash index is bits 31:23 of a CRC-32 register (reflected polynomial 0xEDB88320, preset all ones, no final inversion) after the six destination bytes, fed least significant bit first. Bitmap bit k is bit k mod 64 of word k/64. The hash sub-filter fires when hash_en is 1 and the indexed bit XOR hash_inv is 1.
- R8: The hash sub-filter never fires for a broadcast destination, even when the indexed bit is set.
- R9: When mcast_all is 1, every non-broadcast destination with bit 40 set is accepted. exact_hit and hash_hit still report their sub-filter verdicts.
- R10: When promisc or allpkt is 1, every frame that is not consumed as a pause frame is accepted.
- R11: A broadcast address held in an exact-match entry makes broadcast frames accepted with bcast_en at 0.
- R12: A pause frame has destination 01-80-C2-00-00-01, type 0x8808 and opcode 0x0001. With fwd_pause at 0, such a frame gives pause_consume=1 and accept=0. With fwd_pause at 1, it gives accept=1 and pause_consume=0. Any other opcode on that address and type is filtered normally.
- R13: exact_hit and hash_hit equal the exact and hash sub-filter verdicts. accept is the OR of all sub-filter verdicts and the two pass-all switches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A header byte is present |
| in_sof | input | 1 | Present byte is byte 0 of a frame |
| in_data | input | 8 | Header byte |
| bcast_en | input | 1 | Broadcast sub-filter enable |
| exact_en | input | 1 | Exact sub-filter enable |
| exact_inv | input | 1 | Invert exact result |
| hash_en | input | 1 | Hash sub-filter enable |
| hash_inv | input | 1 | Invert hash bitmap bit |
| mcast_all | input | 1 | Accept all multicast |
| promisc | input | 1 | Promiscuous mode |
| allpkt | input | 1 | Accept every frame |
| fwd_pause | input | 1 | Forward pause frames instead of consuming |
| addr_we | input | 1 | Stored address write strobe |
| addr_sel | input | 3 | Stored address index |
| addr_wdata | input | 48 | Stored address value |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 3 | Mask index (0 or 1 effective) |
| mask_wdata | input | 48 | Mask value |
| map_we | input | 1 | Bitmap word write strobe |
| map_sel | input | 3 | Bitmap word index |
| map_wdata | input | 64 | Bitmap word value |
| dec_valid | output | 1 | One-cycle decision strobe |
| accept | output | 1 | Frame accepted |
| exact_hit | output | 1 | Exact sub-filter verdict |
| hash_hit | output | 1 | Hash sub-filter verdict |
| pause_consume | output | 1 | Pause frame to be consumed by the MAC |

## Verification
Destinations are drawn from five families:

- random unicast;
- random multicast;
- all-ones broadcast;
- copies of stored entries, with masked bits flipped;
- the pause address, with and without the control type and pause opcode.

Each family reaches a different sub-filter. Mode switches and tables are re-randomised between rounds, so the inversions and pass-all paths meet every family.

Directed frames separate the timing of the early decision from the late one. They also cover:

- broadcast let through by a stored entry rather than by the enable;
- a hash bit set for the broadcast index;
- a mask write to an unmasked slot;
- a start marker arriving inside a frame.

// File: rtl/rx_addr_filter_pkg.sv
package rx_addr_filter_pkg;

    localparam int unsigned MAC_W = 48;
    localparam logic [47:0] PAUSE_DA   = 48'h0180C2000001;
    localparam logic [15:0] CTRL_TYPE  = 16'h8808;
    localparam logic [15:0] PAUSE_OPC  = 16'h0001;
    localparam logic [31:0] CRC_POLY_R = 32'hEDB88320;

    typedef struct packed {
        logic bcast_en;
        logic exact_en;
        logic exact_inv;
        logic hash_en;
        logic hash_inv;
        logic mcast_all;
        logic promisc;
        logic allpkt;
        logic fwd_pause;
    } flt_ctl_t;

    typedef struct packed {
        logic              active;
        logic [3:0]        idx;
        logic [MAC_W-1:0]  da;
        logic [7:0]        hi;
        logic [31:0]       crc;
        logic              dv;
        logic              acc;
        logic              exh;
        logic              hsh;
        logic              pcons;
    } fstate_t;

    // Byte-wide reflected CRC-32 step
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/raf_exact_bank.sv
module raf_exact_bank #(
    parameter int N_ENT  = 8,
    parameter int N_MASK = 2,
    parameter int AW     = 48,
    parameter int SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             addr_we,
    input  logic [SEL_W-1:0] addr_sel,
    input  logic [AW-1:0]    addr_wdata,
    input  logic             mask_we,
    input  logic [SEL_W-1:0] mask_sel,
    input  logic [AW-1:0]    mask_wdata,
    input  logic [AW-1:0]    key,
    output logic [N_ENT-1:0] hits
);

    logic [AW-1:0] addr_d [N_ENT];
    logic [AW-1:0] addr_q [N_ENT];
    logic [AW-1:0] mask_d [N_MASK];
    logic [AW-1:0] mask_q [N_MASK];

    always_comb begin
        for (int e = 0; e < N_ENT; e++) begin
            addr_d[e] = addr_q[e];
            if (addr_we && addr_sel == SEL_W'(e)) addr_d[e] = addr_wdata;
        end
        for (int m = 0; m < N_MASK; m++) begin
            mask_d[m] = mask_q[m];
            if (mask_we && mask_sel == SEL_W'(m)) mask_d[m] = mask_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < N_ENT; e++) addr_q[e] <= '0;
            for (int m = 0; m < N_MASK; m++) mask_q[m] <= '1;
        end else begin
            for (int e = 0; e < N_ENT; e++) addr_q[e] <= addr_d[e];
            for (int m = 0; m < N_MASK; m++) mask_q[m] <= mask_d[m];
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        if (g < N_MASK) begin : g_masked
            assign hits[g] = ((key ^ addr_q[g]) & mask_q[g]) == '0;
            // R5: mask store follows its write port
            a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
                mask_we && mask_sel == SEL_W'(g) |=> mask_q[g] == $past(mask_wdata));
        end else begin : g_plain
            assign hits[g] = key == addr_q[g];
        end
        a_r4_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
            addr_we && addr_sel == SEL_W'(g) |=> addr_q[g] == $past(addr_wdata));
    end

endmodule

// File: rtl/raf_hash_map.sv
module raf_hash_map #(
    parameter int WORDS  = 8,
    parameter int WORD_W = 64,
    parameter int SEL_W  = 3,
    parameter int IDX_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SEL_W-1:0]  sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  idx,
    output logic              bit_o
);

    localparam int BSEL_W = $clog2(WORD_W);

    logic [WORD_W-1:0] words_d [WORDS];
    logic [WORD_W-1:0] words_q [WORDS];

    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            words_d[w] = words_q[w];
            if (we && sel == SEL_W'(w)) words_d[w] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
        end else begin
            for (int w = 0; w < WORDS; w++) words_q[w] <= words_d[w];
        end
    end

    assign bit_o = words_q[idx[IDX_W-1:BSEL_W]][idx[BSEL_W-1:0]];

    for (genvar g = 0; g < WORDS; g++) begin : g_chk
        a_r7_map_write: assert property (@(posedge clk) disable iff (!rst_n)
            we && sel == SEL_W'(g) |=> words_q[g] == $past(wdata));
    end

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rx_addr_filter_pkg::*;
#(
    parameter int N_ENT      = 8,
    parameter int N_MASK     = 2,
    parameter int MAP_WORDS  = 8,
    parameter int MAP_WORD_W = 64,
    localparam int ESEL_W    = $clog2(N_ENT),
    localparam int HSEL_W    = $clog2(MAP_WORDS),
    localparam int HIDX_W    = $clog2(MAP_WORDS * MAP_WORD_W)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  in_sof,
    input  logic [7:0]            in_data,
    input  logic                  bcast_en,
    input  logic                  exact_en,
    input  logic                  exact_inv,
    input  logic                  hash_en,
    input  logic                  hash_inv,
    input  logic                  mcast_all,
    input  logic                  promisc,
    input  logic                  allpkt,
    input  logic                  fwd_pause,
    input  logic                  addr_we,
    input  logic [ESEL_W-1:0]     addr_sel,
    input  logic [MAC_W-1:0]      addr_wdata,
    input  logic                  mask_we,
    input  logic [ESEL_W-1:0]     mask_sel,
    input  logic [MAC_W-1:0]      mask_wdata,
    input  logic                  map_we,
    input  logic [HSEL_W-1:0]     map_sel,
    input  logic [MAP_WORD_W-1:0] map_wdata,
    output logic                  dec_valid,
    output logic                  accept,
    output logic                  exact_hit,
    output logic                  hash_hit,
    output logic                  pause_consume
);

    flt_ctl_t         ctl;
    fstate_t          s_d, s_q;
    logic [N_ENT-1:0] ex_hits;
    logic             map_bit;
    logic             is_bcast, is_mcast, exact_sub, hash_sub, normal_acc;
    logic [3:0]       cur_idx;

    assign ctl = '{bcast_en: bcast_en, exact_en: exact_en, exact_inv: exact_inv,
                   hash_en: hash_en, hash_inv: hash_inv, mcast_all: mcast_all,
                   promisc: promisc, allpkt: allpkt, fwd_pause: fwd_pause};

    raf_exact_bank #(
        .N_ENT (N_ENT),
        .N_MASK(N_MASK),
        .AW    (MAC_W),
        .SEL_W (ESEL_W)
    ) u_exact (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_we   (addr_we),
        .addr_sel  (addr_sel),
        .addr_wdata(addr_wdata),
        .mask_we   (mask_we),
        .mask_sel  (mask_sel),
        .mask_wdata(mask_wdata),
        .key       (s_q.da),
        .hits      (ex_hits)
    );

    raf_hash_map #(
        .WORDS (MAP_WORDS),
        .WORD_W(MAP_WORD_W),
        .SEL_W (HSEL_W),
        .IDX_W (HIDX_W)
    ) u_hash (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (map_we),
        .sel  (map_sel),
        .wdata(map_wdata),
        .idx  (s_q.crc[31 -: HIDX_W]),
        .bit_o(map_bit)
    );

    always_comb begin
        is_bcast   = &s_q.da;
        is_mcast   = s_q.da[40] & ~is_bcast;
        exact_sub  = ctl.exact_en & ((|ex_hits) ^ ctl.exact_inv);
        hash_sub   = ctl.hash_en & (map_bit ^ ctl.hash_inv) & ~is_bcast;
        normal_acc = (is_bcast & ctl.bcast_en) | exact_sub | hash_sub
                   | (is_mcast & ctl.mcast_all) | ctl.promisc | ctl.allpkt;
        cur_idx    = in_sof ? 4'd0 : s_q.idx;

        s_d    = s_q;
        s_d.dv = 1'b0;
        if (in_valid && (in_sof || s_q.active)) begin
            s_d.active = 1'b1;
            s_d.idx    = cur_idx + 4'd1;
            if (cur_idx < 4'd6) begin
                s_d.da  = {s_q.da[MAC_W-9:0], in_data};
                s_d.crc = crc32_step(in_sof ? 32'hFFFF_FFFF : s_q.crc, in_data);
            end
            if (cur_idx == 4'd12 || cur_idx == 4'd14) s_d.hi = in_data;
            if ((cur_idx == 4'd13 && !(s_q.da == PAUSE_DA && {s_q.hi, in_data} == CTRL_TYPE))
                || cur_idx == 4'd15) begin
                s_d.dv     = 1'b1;
                s_d.active = 1'b0;
                s_d.exh    = exact_sub;
                s_d.hsh    = hash_sub;
                if (cur_idx == 4'd15 && {s_q.hi, in_data} == PAUSE_OPC) begin
                    s_d.acc   = ctl.fwd_pause;
                    s_d.pcons = ~ctl.fwd_pause;
                end else begin
                    s_d.acc   = normal_acc;
                    s_d.pcons = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dec_valid     = s_q.dv;
    assign accept        = s_q.acc;
    assign exact_hit     = s_q.exh;
    assign hash_hit      = s_q.hsh;
    assign pause_consume = s_q.pcons;

    a_r12_pause_excl: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !(accept && pause_consume));

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    a_r10_promisc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && !pause_consume && $past(promisc || allpkt) |-> accept);

    a_r8_hash_no_bcast: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && hash_hit |-> !$past(is_bcast));

endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam logic [47:0] P_DA  = 48'h0180C2000001;
    localparam logic [47:0] BC_DA = 48'hFFFFFFFFFFFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 0, in_sof = 0;
    logic [7:0] in_data = '0;
    logic bcast_en = 0, exact_en = 0, exact_inv = 0, hash_en = 0, hash_inv = 0;
    logic mcast_all = 0, promisc = 0, allpkt = 0, fwd_pause = 0;
    logic addr_we = 0, mask_we = 0, map_we = 0;
    logic [2:0] addr_sel = '0, mask_sel = '0, map_sel = '0;
    logic [47:0] addr_wdata = '0, mask_wdata = '0;
    logic [63:0] map_wdata = '0;
    logic dec_valid, accept, exact_hit, hash_hit, pause_consume;

    logic [47:0] m_addr [8];
    logic [47:0] m_mask [2];
    logic [63:0] m_map  [8];

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
        .bcast_en(bcast_en), .exact_en(exact_en), .exact_inv(exact_inv), .hash_en(hash_en),
        .hash_inv(hash_inv), .mcast_all(mcast_all), .promisc(promisc), .allpkt(allpkt),
        .fwd_pause(fwd_pause), .addr_we(addr_we), .addr_sel(addr_sel), .addr_wdata(addr_wdata),
        .mask_we(mask_we), .mask_sel(mask_sel), .mask_wdata(mask_wdata), .map_we(map_we),
        .map_sel(map_sel), .map_wdata(map_wdata), .dec_valid(dec_valid), .accept(accept),
        .exact_hit(exact_hit), .hash_hit(hash_hit), .pause_consume(pause_consume)
    );

    function automatic logic [31:0] ref_crc(input logic [47:0] da);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int b = 0; b < 6; b++) begin
            for (int k = 0; k < 8; k++) begin
                logic fb;
                fb = c[0] ^ da[47 - 8*b - 7 + k];
                c  = {1'b0, c[31:1]};
                if (fb) c = c ^ 32'hEDB88320;
            end
        end
        return c;
    endfunction

    function automatic logic [8:0] ref_idx(input logic [47:0] da);
        logic [31:0] c = ref_crc(da);
        return c[31:23];
    endfunction

    // expected {accept, exact_hit, hash_hit, pause_consume}
    function automatic logic [3:0] ref_decide(input logic [47:0] da, input logic [15:0] typ,
                                              input logic [15:0] opc);
        logic bc, mc, raw, ex, hs, bitv, acc, pc;
        logic [8:0] hi;
        bc  = (da == BC_DA);
        mc  = da[40] && !bc;
        raw = 0;
        for (int i = 0; i < 8; i++) begin
            logic [47:0] msk;
            msk = (i < 2) ? m_mask[i] : '1;
            if (((da ^ m_addr[i]) & msk) == '0) raw = 1;
        end
        ex   = exact_en && (raw ^ exact_inv);
        hi   = ref_idx(da);
        bitv = m_map[hi[8:6]][hi[5:0]];
        hs   = hash_en && (bitv ^ hash_inv) && !bc;
        if (da == P_DA && typ == 16'h8808 && opc == 16'h0001) begin
            acc = fwd_pause; pc = !fwd_pause;
        end else begin
            acc = (bc && bcast_en) || ex || hs || (mc && mcast_all) || promisc || allpkt;
            pc  = 0;
        end
        return {acc, ex, hs, pc};
    endfunction

    task automatic wr_addr(input int i, input logic [47:0] v);
        @(negedge clk); addr_we = 1; addr_sel = 3'(i); addr_wdata = v;
        @(negedge clk); addr_we = 0;
        m_addr[i] = v;
    endtask

    task automatic wr_mask(input int i, input logic [47:0] v);
        @(negedge clk); mask_we = 1; mask_sel = 3'(i); mask_wdata = v;
        @(negedge clk); mask_we = 0;
        if (i < 2) m_mask[i] = v;   // R5: upper indices have no mask
    endtask

    task automatic wr_map(input int i, input logic [63:0] v);
        @(negedge clk); map_we = 1; map_sel = 3'(i); map_wdata = v;
        @(negedge clk); map_we = 0;
        m_map[i] = v;
    endtask

    function automatic logic [7:0] frame_byte(input int i, input logic [47:0] da,
                                              input logic [15:0] typ, input logic [15:0] opc);
        if (i < 6)        return da[47 - 8*i -: 8];
        else if (i == 12) return typ[15:8];
        else if (i == 13) return typ[7:0];
        else if (i == 14) return opc[15:8];
        else if (i == 15) return opc[7:0];
        else              return 8'($urandom);
    endfunction

    task automatic send_partial(input logic [47:0] da, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1; in_sof = (i == 0); in_data = frame_byte(i, da, 16'h0800, 16'h0);
        end
    endtask

    task automatic send_frame(input string tag, input logic [47:0] da, input logic [15:0] typ,
                              input logic [15:0] opc);
        int exp_pos, got_pos, pulses;
        logic [3:0] exp_v, got_v;
        exp_pos = (da == P_DA && typ == 16'h8808) ? 15 : 13;
        exp_v   = ref_decide(da, typ, opc);
        got_pos = -1; pulses = 0; got_v = '0;
        for (int i = 0; i <= 17; i++) begin
            @(negedge clk);
            if (dec_valid) begin
                pulses++; got_pos = i - 1;
                got_v = {accept, exact_hit, hash_hit, pause_consume};
            end
            if (i < 16) begin
                in_valid = 1; in_sof = (i == 0); in_data = frame_byte(i, da, typ, opc);
            end else begin
                in_valid = 0; in_sof = 0;
            end
        end
        n_vec++;
        if (pulses != 1 || got_pos != exp_pos) begin
            n_bad++;
            $display("FAIL R2 (%s) da=%h: strobe after byte %0d x%0d, expected byte %0d x1",
                     tag, da, got_pos, pulses, exp_pos);
        end else if (got_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s da=%h typ=%h opc=%h: {acc,ex,hs,pc}=%b expected %b",
                     tag, da, typ, opc, got_v, exp_v);
        end
    endtask

    task automatic set_modes(input logic [8:0] m);
        @(negedge clk);
        {bcast_en, exact_en, exact_inv, hash_en, hash_inv, mcast_all, promisc, allpkt, fwd_pause} = m;
    endtask

    function automatic logic [47:0] rnd_da(input int kind);
        logic [47:0] d;
        d = {16'($urandom), 32'($urandom)};
        case (kind)
            0: d[40] = 1'b0;
            1: begin d[40] = 1'b1; if (d == BC_DA) d[0] = 1'b0; end
            2: d = BC_DA;
            3: begin
                int e;
                e = int'($urandom_range(0, 7));
                d = m_addr[e];
                if (e < 2) d = d ^ (~m_mask[e] & {16'($urandom), 32'($urandom)});
               end
            default: d = P_DA;
        endcase
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual no end, expected end");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        logic [8:0]  hx;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin m_addr[i] = '0; m_map[i] = '0; end
        m_mask[0] = '1; m_mask[1] = '1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset outputs
        n_vec++;
        if ({dec_valid, accept, exact_hit, hash_hit, pause_consume} !== 5'b0) begin
            n_bad++;
            $display("FAIL R1 outputs=%b expected 00000",
                     {dec_valid, accept, exact_hit, hash_hit, pause_consume});
        end
        // R1: reset tables (zero entries, empty bitmap)
        set_modes(9'b010100000);
        send_frame("R1", 48'h000000000000, 16'h0800, 16'h0);
        send_frame("R1", 48'h00AABBCCDDEE, 16'h0800, 16'h0);

        // R3 broadcast enable
        set_modes(9'b000000000);
        send_frame("R3", BC_DA, 16'h0800, 16'h0);
        set_modes(9'b100000000);
        send_frame("R3", BC_DA, 16'h0800, 16'h0);

        // R4 exact match, all entries live
        wr_addr(5, 48'h02_11_22_33_44_55);
        set_modes(9'b010000000);
        send_frame("R4", 48'h021122334455, 16'h0800, 16'h0);
        send_frame("R4", 48'h021122334454, 16'h0800, 16'h0);
        // R6 inversion
        set_modes(9'b011000000);
        send_frame("R6", 48'h021122334455, 16'h0800, 16'h0);
        send_frame("R6", 48'h021122334454, 16'h0800, 16'h0);

        // R5 masked entry and ignored mask write
        wr_addr(0, 48'h04_00_00_00_10_00);
        wr_mask(0, 48'hFFFF_FFFF_F000);
        set_modes(9'b010000000);
        send_frame("R5", 48'h040000000ABC, 16'h0800, 16'h0);
        wr_addr(2, 48'h06_00_00_00_00_01);
        wr_mask(2, 48'h0);
        send_frame("R5", 48'h060000000003, 16'h0800, 16'h0);

        // R7 hash lookup, R8 broadcast exclusion
        a  = 48'h0A0B0C0D0E0F;
        hx = ref_idx(a);
        wr_map(int'(hx[8:6]), m_map[hx[8:6]] | (64'd1 << hx[5:0]));
        set_modes(9'b000100000);
        send_frame("R7", a, 16'h0800, 16'h0);
        set_modes(9'b000110000);
        send_frame("R7", a, 16'h0800, 16'h0);
        hx = ref_idx(BC_DA);
        wr_map(int'(hx[8:6]), m_map[hx[8:6]] | (64'd1 << hx[5:0]));
        set_modes(9'b000100000);
        send_frame("R8", BC_DA, 16'h0800, 16'h0);

        // R9 multicast pass with flags kept
        set_modes(9'b010101000);
        send_frame("R9", 48'h0B0000000001, 16'h0800, 16'h0);
        send_frame("R9", 48'h0A0000000001, 16'h0800, 16'h0);

        // R10 promisc / allpkt
        set_modes(9'b000000100);
        send_frame("R10", 48'h0C1234567890, 16'h0800, 16'h0);
        set_modes(9'b000000010);
        send_frame("R10", 48'h0C1234567890, 16'h0800, 16'h0);

        // R11 broadcast in exact slot
        wr_addr(7, BC_DA);
        set_modes(9'b010000000);
        send_frame("R11", BC_DA, 16'h0800, 16'h0);
        wr_addr(7, 48'h0);

        // R12 pause frames and R2 late decision
        set_modes(9'b000000100);
        send_frame("R12", P_DA, 16'h8808, 16'h0001);
        set_modes(9'b000000001);
        send_frame("R12", P_DA, 16'h8808, 16'h0001);
        set_modes(9'b000001000);
        send_frame("R12", P_DA, 16'h8808, 16'h0002);
        send_frame("R2", P_DA, 16'h0800, 16'h0001);

        // R2 restart in mid-frame
        send_partial(48'h0E0000000000, 8);
        send_frame("R2", 48'h0F0000000000, 16'h0800, 16'h0);

        // R13 random rounds
        for (int r = 0; r < 4; r++) begin
            for (int i = 0; i < 8; i++) wr_addr(i, rnd_da(int'($urandom_range(0, 1))));
            for (int i = 0; i < 2; i++) wr_mask(i, {16'($urandom), 32'($urandom)} | 48'hFFFF_0000_0000);
            for (int i = 0; i < 8; i++) wr_map(i, {32'($urandom), 32'($urandom)});
            set_modes(9'($urandom) & (r == 0 ? 9'b111111001 : 9'b111111111));
            for (int f = 0; f < 120; f++) begin
                int k;
                logic [15:0] ty, op;
                k  = int'($urandom_range(0, 4));
                ty = ($urandom_range(0, 1) == 1) ? 16'h8808 : 16'($urandom);
                op = ($urandom_range(0, 1) == 1) ? 16'h0001 : 16'($urandom);
                send_frame("R13", rnd_da(k), ty, op);
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule